// File: doc/BRIEF.md
# Packed-BCD Decimal Adjust Unit

This block repairs an 8-bit accumulator after a binary add or subtract of two packed-BCD operands, so that the value holds two valid decimal digits again. It takes the raw accumulator and three incoming flags: a carry, a half-carry and an add/subtract indicator. It returns the corrected accumulator and a full set of condition flags: sign, zero, half-carry, parity, subtract and carry.

The correction logic is purely combinational. A single register stage captures the result and flags whenever the input strobe is high, so results appear one clock after the operands. Both correction decisions are taken from the original accumulator value. The incoming half-carry can force a low-digit fix even when that digit already reads 0 to 9.

Top module: `bcd_adjust_unit`

## Requirements
- R1: A low correction of 0x06 is selected when the low nibble of `acc_in` is greater than 9 or `h_in` is 1. Both correction decisions look only at the original `acc_in`.
- R2: `h_out` is 1 exactly when the low correction was selected, and 0 otherwise.
- R3: A high correction of 0x60 is selected when `c_in` is 1 or `acc_in` is greater than 0x99. `c_out` is 1 exactly when the high correction was selected, so an incoming carry is never cleared.
- R4: With `n_in` = 0 the selected corrections are added to `acc_in`. With `n_in` = 1 they are subtracted. The same selection conditions apply in both cases, and the arithmetic wraps modulo 256.
- R5: `s_out` equals bit 7 of the corrected result.
- R6: `z_out` is 1 exactly when the corrected 8-bit result is 0x00.
- R7: `pv_out` is 1 when the corrected result has an even number of set bits, and 0 when that number is odd.
- R8: `n_out` repeats `n_in` unchanged.
- R9: The result and all flags are loaded on the rising clock edge while `in_valid` is 1, and they appear one cycle after the operands. While `in_valid` is 0, every output holds its value.
- R10: A synchronous active-high `rst` clears `acc_out` and every flag output to 0, and it takes priority over `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Load strobe for the output register |
| acc_in | input | 8 | Accumulator value after the binary operation |
| c_in | input | 1 | Incoming carry flag |
| h_in | input | 1 | Incoming half-carry flag |
| n_in | input | 1 | Incoming subtract flag (1 = last operation was a subtract) |
| acc_out | output | 8 | Decimal-adjusted accumulator |
| s_out | output | 1 | Sign flag |
| z_out | output | 1 | Zero flag |
| h_out | output | 1 | Half-carry flag (low digit was corrected) |
| pv_out | output | 1 | Parity flag (1 = even) |
| n_out | output | 1 | Subtract flag, passed through |
| c_out | output | 1 | Carry flag (high digit was corrected) |

## Verification
A wrong correction choice shows on the ports one cycle after the strobe. `acc_out` is then off by 0x06 or 0x60, and `h_out` or `c_out` disagrees with the rule for the input value. Because the register holds its contents while the strobe is low, a stale or corrupted register stays visible on the same ports until the next load. Derived flags that do not match the held result expose a broken flag path in that same cycle. The corner cases exercised are:
- a forced low fix from `h_in` with a low digit in the range 0 to 9,
- the value 0x99 with `h_in` set, which must not trigger the high fix because the decision uses the original value,
- results that wrap to zero or roll past 0xFF.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;

    localparam int ACC_W    = 8;
    localparam int NIB_W    = ACC_W / 2;
    localparam int DIGIT_MAX = 9;
    localparam logic [NIB_W-1:0] NIB_FIX = NIB_W'(6);

    typedef logic [ACC_W-1:0] acc_t;

    typedef struct packed {
        logic sgn;
        logic zero;
        logic half;
        logic par;
        logic sub;
        logic carry;
    } flag_set_t;

    typedef struct packed {
        logic fix_lo;
        logic fix_hi;
    } fix_sel_t;

    function automatic logic even_parity(input acc_t v);
        return ~(^v);
    endfunction

    function automatic acc_t fix_word(input fix_sel_t sel);
        acc_t w;
        w = '0;
        if (sel.fix_lo) w[NIB_W-1:0]     = NIB_FIX;
        if (sel.fix_hi) w[ACC_W-1:NIB_W] = NIB_FIX;
        return w;
    endfunction

endpackage

// File: rtl/bcd_fix_select.sv
module bcd_fix_select
    import bcd_adj_pkg::*;
(
    input  acc_t     acc,
    input  logic     carry_in,
    input  logic     half_in,
    output fix_sel_t sel
);
    localparam acc_t HI_LIMIT = {NIB_W'(DIGIT_MAX), NIB_W'(DIGIT_MAX)};

    always_comb begin
        sel.fix_lo = half_in  || (acc[NIB_W-1:0] > NIB_W'(DIGIT_MAX));
        sel.fix_hi = carry_in || (acc > HI_LIMIT);
    end
endmodule

// File: rtl/bcd_fix_apply.sv
module bcd_fix_apply
    import bcd_adj_pkg::*;
(
    input  acc_t      acc,
    input  logic      sub_in,
    input  fix_sel_t  sel,
    output acc_t      result,
    output flag_set_t flags
);
    acc_t corr;

    always_comb begin
        corr   = fix_word(sel);
        result = sub_in ? (acc - corr) : (acc + corr);
        flags.sgn   = result[ACC_W-1];
        flags.zero  = (result == '0);
        flags.half  = sel.fix_lo;
        flags.par   = even_parity(result);
        flags.sub   = sub_in;
        flags.carry = sel.fix_hi;
    end
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
    import bcd_adj_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [ACC_W-1:0] acc_in,
    input  logic             c_in,
    input  logic             h_in,
    input  logic             n_in,
    output logic [ACC_W-1:0] acc_out,
    output logic             s_out,
    output logic             z_out,
    output logic             h_out,
    output logic             pv_out,
    output logic             n_out,
    output logic             c_out
);
    fix_sel_t  sel;
    acc_t      res_d, res_q;
    flag_set_t flg_d, flg_q;

    bcd_fix_select u_sel (
        .acc      (acc_in),
        .carry_in (c_in),
        .half_in  (h_in),
        .sel      (sel)
    );

    bcd_fix_apply u_apply (
        .acc    (acc_in),
        .sub_in (n_in),
        .sel    (sel),
        .result (res_d),
        .flags  (flg_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            flg_q <= '0;
        end else if (in_valid) begin
            res_q <= res_d;
            flg_q <= flg_d;
        end
    end

    assign acc_out = res_q;
    assign s_out   = flg_q.sgn;
    assign z_out   = flg_q.zero;
    assign h_out   = flg_q.half;
    assign pv_out  = flg_q.par;
    assign n_out   = flg_q.sub;
    assign c_out   = flg_q.carry;
endmodule

// File: rtl/bcd_adjust_unit_chk.sv
module bcd_adjust_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [7:0] acc_in,
    input logic       c_in,
    input logic       h_in,
    input logic       n_in,
    input logic [7:0] acc_out,
    input logic       s_out,
    input logic       z_out,
    input logic       h_out,
    input logic       pv_out,
    input logic       n_out,
    input logic       c_out
);
    a_r2_half_rule: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> h_out == ($past(h_in) || ($past(acc_in[3:0]) > 4'd9)));

    a_r3_carry_rule: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> c_out == ($past(c_in) || ($past(acc_in) > 8'h99)));

    a_r8_sub_pass: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> n_out == $past(n_in));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(acc_out) && $stable(c_out) && $stable(h_out)));

    a_r10_reset_clear: assert property (@(posedge clk)
        rst |=> (acc_out == 8'h00 && !c_out && !h_out && !z_out && !pv_out));
endmodule

bind bcd_adjust_unit bcd_adjust_unit_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .acc_in   (acc_in),
    .c_in     (c_in),
    .h_in     (h_in),
    .n_in     (n_in),
    .acc_out  (acc_out),
    .s_out    (s_out),
    .z_out    (z_out),
    .h_out    (h_out),
    .pv_out   (pv_out),
    .n_out    (n_out),
    .c_out    (c_out)
);

// File: tb/bcd_adjust_unit_tb_top.sv
module bcd_adjust_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] acc_in = 8'h00;
    logic       c_in = 1'b0, h_in = 1'b0, n_in = 1'b0;
    logic [7:0] acc_out;
    logic       s_out, z_out, h_out, pv_out, n_out, c_out;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    bcd_adjust_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .acc_in(acc_in),
        .c_in(c_in), .h_in(h_in), .n_in(n_in), .acc_out(acc_out),
        .s_out(s_out), .z_out(z_out), .h_out(h_out), .pv_out(pv_out),
        .n_out(n_out), .c_out(c_out)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] got, input logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // Expected value straight from the requirements.
    task automatic apply_and_check(input string tag, input logic [7:0] a,
                                   input logic c, input logic h, input logic n);
        logic lo, hi;
        logic [7:0] corr, res;
        lo   = h || (a[3:0] > 4'd9);                  // R1
        hi   = c || (a > 8'h99);                      // R3
        corr = (lo ? 8'h06 : 8'h00) | (hi ? 8'h60 : 8'h00);
        res  = n ? a - corr : a + corr;               // R4
        @(negedge clk);
        acc_in = a; c_in = c; h_in = h; n_in = n; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R4"}, "acc", acc_out, res);
        check({tag, " R2"}, "h", {7'd0, h_out}, {7'd0, lo});
        check({tag, " R3"}, "c", {7'd0, c_out}, {7'd0, hi});
        check({tag, " R5"}, "s", {7'd0, s_out}, {7'd0, res[7]});
        check({tag, " R6"}, "z", {7'd0, z_out}, {7'd0, res == 8'h00});
        check({tag, " R7"}, "pv", {7'd0, pv_out}, {7'd0, ~(^res)});
        check({tag, " R8"}, "n", {7'd0, n_out}, {7'd0, n});
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R10", "acc", acc_out, 8'h00);
        check("R10", "flags", {2'b0, s_out, z_out, h_out, pv_out, n_out, c_out}, 8'h00);
    endtask

    task automatic test_add();
        apply_and_check("R1 add low>9", 8'h3C, 1'b0, 1'b0, 1'b0);
        apply_and_check("R1 forced by h", 8'h12, 1'b0, 1'b1, 1'b0);
        apply_and_check("R3 over 0x99", 8'hA3, 1'b0, 1'b0, 1'b0);
        apply_and_check("R3 carry kept", 8'h25, 1'b1, 1'b0, 1'b0);
        apply_and_check("add no fix", 8'h47, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic test_sub();
        apply_and_check("R4 sub h", 8'h2E, 1'b0, 1'b1, 1'b1);
        apply_and_check("R4 sub c", 8'hF5, 1'b1, 1'b0, 1'b1);
        apply_and_check("R4 sub both", 8'hFA, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic test_corners();
        apply_and_check("R1 original 0x99", 8'h99, 1'b0, 1'b1, 1'b0); // expect 0x9F, no high fix
        apply_and_check("R6 wrap zero", 8'h9A, 1'b0, 1'b0, 1'b0);     // 0x00
        apply_and_check("R4 wrap FF", 8'hFF, 1'b0, 1'b0, 1'b0);       // 0x65
        apply_and_check("R4 sub wrap", 8'h03, 1'b1, 1'b1, 1'b1);      // 0x9D
    endtask

    task automatic test_hold();
        logic [7:0] keep;
        apply_and_check("R9 load", 8'h3C, 1'b0, 1'b0, 1'b0);
        keep = acc_out;
        @(negedge clk);
        acc_in = 8'hFF; c_in = 1'b1; h_in = 1'b1; n_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R9", "acc hold", acc_out, keep);
        check("R9", "c hold", {7'd0, c_out}, 8'h00);
        check("R9", "n hold", {7'd0, n_out}, 8'h00);
        // reset priority over strobe
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        check("R10", "acc after rst", acc_out, 8'h00);
        check("R10", "c after rst", {7'd0, c_out}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_add();
        test_sub();
        test_corners();
        test_hold();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule